// File: doc/BRIEF.md
# Serial Flash Deep Power-Down and Signature Controller

This block is the slave-side command logic of a serial flash part that handles entering and leaving the lowest-power mode. It watches chip select, serial clock and serial data-in through two-flop synchronisers on a fast system clock. It decodes the first eight bits of each transaction as an opcode and drives serial data-out. A `busy` input from the rest of the device says that an erase, program or status write is running. While that input is high, the commands here are not decoded.

One opcode parks the device in deep power-down. While the device is parked, only the wake-up opcode is honoured. The wake-up opcode is followed by three dummy bytes. After them the device returns an 8-bit signature, and it keeps returning it for as long as the host keeps clocking. The wake-up opcode also works in standby, where it only reads the signature. When it wakes the device, standby comes back only after a counted delay in system clock cycles, measured from the rise of chip select. Three status outputs show the current mode so that the surrounding logic can observe it.

Top module: `flash_pd_ctrl`

## Requirements
- R1: After reset the mode is standby (`st_standby`=1, `st_deep_pd`=0, `st_releasing`=0), and `spi_miso` and `spi_miso_oe` are 0.
- R2: Opcode 0xB9, sent MSB first, enters deep power-down only when chip select rises after exactly 8 clocked bits, in standby, and with `busy` low. Transactions of 7 or 9 bits do not enter it.
- R3: In deep power-down, any opcode other than 0xAB (for example 0x9F or 0xB9) leaves the mode unchanged.
- R4: After opcode 0xAB and 24 dummy bits, `spi_miso` returns the signature 0x12 MSB first. Each bit changes after a falling serial-clock edge and is valid at the next rising edge.
- R5: While chip select stays low and clocks continue after the first signature byte, the signature repeats with no gap.
- R6: With `busy` high when the eighth opcode bit is taken in, neither 0xAB nor 0xB9 is decoded. The mode is unchanged and `spi_miso` stays 0.
- R7: Opcode 0xAB in standby outputs the signature, and the mode stays standby after chip select rises.
- R8: Opcode 0xAB in deep power-down sets `st_releasing` within a few system cycles of chip select rising. The mode turns to standby after TRES system cycles (default 64).
- R9: An 0xAB transaction cut short before the full 8 opcode bits leaves deep power-down unchanged.
- R10: Any opcode received while the release delay runs is ignored. A 0xB9 sent then does not lead to deep power-down, and `spi_miso` stays 0.
- R11: `spi_miso_oe` is 1 only while the synchronised chip select is low. `spi_miso` is 0 whenever `spi_miso_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data-in |
| busy | input | 1 | Erase, program or status write in progress |
| spi_miso | output | 1 | Serial data-out |
| spi_miso_oe | output | 1 | Output enable for serial data-out |
| st_deep_pd | output | 1 | Device is in deep power-down |
| st_releasing | output | 1 | Release delay is running |
| st_standby | output | 1 | Device is in standby |

## Verification
A wrong mode register shows up on the status outputs about four system cycles after chip select rises. A wrong bit counter or command latch shows up at the pins as a signature that starts one bit early or late, shifted or missing bits, or data-out that does not stay quiet. Each of these is seen at the next rising serial-clock edge. A release counter that is too short or too long turns the device back to standby early or late. Checks just inside each end of the delay window catch this.

// File: rtl/pd_pkg.sv
`timescale 1ns/1ps
// Shared types for the deep power-down controller.
// Assumes: one opcode of OP_BITS bits starts every transaction.
package pd_pkg;
    localparam int OP_BITS = 8;

    typedef enum logic [1:0] {
        MODE_STBY = 2'd0,
        MODE_DEEP = 2'd1,
        MODE_REL  = 2'd2
    } pd_mode_e;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_DPD  = 2'd1,
        CMD_RES  = 2'd2
    } pd_cmd_e;
endpackage

// File: rtl/pd_sync.sv
`timescale 1ns/1ps
// Two-flop synchroniser bank, one chain per bit.
// Assumes: inputs are slow relative to clk; RST_VAL gives each bit's idle level.
module pd_sync #(
    parameter int         W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            logic meta_q, sync_q;
            // Two-stage capture of one asynchronous bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= RST_VAL[g];
                    sync_q <= RST_VAL[g];
                end else begin
                    meta_q <= d_async[g];
                    sync_q <= meta_q;
                end
            end
            assign q_sync[g] = sync_q;
        end
    endgenerate
endmodule

// File: rtl/pd_decode.sv
`timescale 1ns/1ps
// Opcode decoder: maps a completed opcode to a command, honouring mode and busy.
// Assumes: op_byte is valid in the cycle the eighth bit is taken in.
module pd_decode
    import pd_pkg::*;
#(
    parameter logic [7:0] OP_DPD = 8'hB9,
    parameter logic [7:0] OP_RES = 8'hAB
) (
    input  logic [7:0] op_byte,
    input  logic       busy,
    input  pd_mode_e   mode,
    output pd_cmd_e    cmd
);
    // Busy or a running release blocks all decoding; deep mode only admits wake-up.
    always_comb begin
        cmd = CMD_NONE;
        if (!busy && mode != MODE_REL) begin
            if (op_byte == OP_RES)
                cmd = CMD_RES;
            else if (op_byte == OP_DPD && mode == MODE_STBY)
                cmd = CMD_DPD;
        end
    end
endmodule

// File: rtl/pd_rx.sv
`timescale 1ns/1ps
// Serial front end: counts and shifts input bits, latches the decoded command,
// and streams the signature after the dummy bits.
// Assumes: sck_rise/sck_fall are one-cycle pulses gated by chip select low.
module pd_rx
    import pd_pkg::*;
#(
    parameter int              DUMMY_BITS = 24,
    parameter int              SIG_W      = 8,
    parameter logic [SIG_W-1:0] SIG       = 8'h12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n_s,
    input  logic       sck_rise,
    input  logic       sck_fall,
    input  logic       mosi_s,
    input  pd_cmd_e    cmd_next,
    output logic [7:0] op_byte,
    output logic       op_strobe,
    output pd_cmd_e    cmd_q,
    output logic       op_exact,
    output logic       miso,
    output logic       miso_oe
);
    localparam int SIG_START = OP_BITS + DUMMY_BITS;
    localparam int CNT_MAX   = SIG_START + 1;
    localparam int CW        = $clog2(CNT_MAX + 1);
    localparam int IW        = (SIG_W > 1) ? $clog2(SIG_W) : 1;

    logic [CW-1:0] bit_cnt;
    logic [6:0]    shreg;
    logic [IW-1:0] sig_idx;

    assign op_byte   = {shreg, mosi_s};
    assign op_strobe = sck_rise && (bit_cnt == CW'(OP_BITS - 1));
    assign op_exact  = (bit_cnt == CW'(OP_BITS));

    // Bit counter (saturating) and input shift register, cleared while deselected.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (sck_rise) begin
            shreg <= {shreg[5:0], mosi_s};
            if (bit_cnt != CW'(CNT_MAX))
                bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Command latch: taken at the eighth bit, dropped once deselect is seen.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s)
            cmd_q <= CMD_NONE;
        else if (op_strobe)
            cmd_q <= cmd_next;
    end

    // Signature shifter: one bit per falling clock edge, wrapping without a gap.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s) begin
            miso    <= 1'b0;
            sig_idx <= '0;
        end else if (sck_fall && cmd_q == CMD_RES && bit_cnt >= CW'(SIG_START)) begin
            miso    <= SIG[IW'(SIG_W - 1) - sig_idx];
            sig_idx <= (sig_idx == IW'(SIG_W - 1)) ? '0 : sig_idx + 1'b1;
        end
    end

    // Output enable follows synchronised chip select.
    always_ff @(posedge clk) begin
        if (!rst_n)
            miso_oe <= 1'b0;
        else
            miso_oe <= !cs_n_s;
    end

    p_oe_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (!miso_oe && !miso));
    p_miso_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_s && !$past(sck_fall)) |-> $stable(miso));
    p_cmd_needs_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q != CMD_NONE) |-> (bit_cnt >= CW'(OP_BITS)));
endmodule

// File: rtl/pd_mode.sv
`timescale 1ns/1ps
// Power-mode state machine with the release delay counter.
// Assumes: cmd_q and op_exact still hold the finished transaction in the
// cycle cs_rise pulses.
module pd_mode
    import pd_pkg::*;
#(
    parameter int TRES = 64
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cs_rise,
    input  pd_cmd_e  cmd_q,
    input  logic     op_exact,
    output pd_mode_e mode
);
    localparam int TW = (TRES > 1) ? $clog2(TRES) : 1;

    logic [TW-1:0] rel_cnt;

    // Mode transitions at the end of a transaction; the delay runs down on its own.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode    <= MODE_STBY;
            rel_cnt <= '0;
        end else begin
            case (mode)
                MODE_STBY: begin
                    if (cs_rise && cmd_q == CMD_DPD && op_exact)
                        mode <= MODE_DEEP;
                end
                MODE_DEEP: begin
                    if (cs_rise && cmd_q == CMD_RES) begin
                        mode    <= MODE_REL;
                        rel_cnt <= TW'(TRES - 1);
                    end
                end
                MODE_REL: begin
                    if (rel_cnt == '0)
                        mode <= MODE_STBY;
                    else
                        rel_cnt <= rel_cnt - 1'b1;
                end
                default: mode <= MODE_STBY;
            endcase
        end
    end

    p_deep_from_stby_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode == MODE_DEEP) |-> ($past(mode) == MODE_STBY));
    p_rel_from_deep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode == MODE_REL) |-> ($past(mode) == MODE_DEEP));
    p_rel_to_stby_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode == MODE_REL) |-> (mode == MODE_STBY));
endmodule

// File: rtl/flash_pd_ctrl.sv
`timescale 1ns/1ps
// Top of the deep power-down controller: synchronises the serial pins,
// finds clock and select edges, and joins the receiver, decoder and mode FSM.
// Assumes: clk runs at least eight times faster than the serial clock.
module flash_pd_ctrl
    import pd_pkg::*;
#(
    parameter int         TRES       = 64,
    parameter int         DUMMY_BITS = 24,
    parameter logic [7:0] SIG        = 8'h12,
    parameter logic [7:0] OP_DPD     = 8'hB9,
    parameter logic [7:0] OP_RES     = 8'hAB
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_mosi,
    input  logic busy,
    output logic spi_miso,
    output logic spi_miso_oe,
    output logic st_deep_pd,
    output logic st_releasing,
    output logic st_standby
);
    logic [2:0] pins_s;
    logic       cs_n_s, sck_s, mosi_s;
    logic       cs_n_d, sck_d;
    logic       sck_rise, sck_fall, cs_rise;
    logic [7:0] op_byte;
    logic       op_strobe, op_exact;
    pd_cmd_e    cmd_next, cmd_q;
    pd_mode_e   mode;

    pd_sync #(.W(3), .RST_VAL(3'b100)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({spi_cs_n, spi_sck, spi_mosi}),
        .q_sync  (pins_s)
    );
    assign {cs_n_s, sck_s, mosi_s} = pins_s;

    // Previous samples for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_d <= 1'b1;
            sck_d  <= 1'b0;
        end else begin
            cs_n_d <= cs_n_s;
            sck_d  <= sck_s;
        end
    end

    assign sck_rise = !cs_n_s && sck_s && !sck_d;
    assign sck_fall = !cs_n_s && !sck_s && sck_d;
    assign cs_rise  = cs_n_s && !cs_n_d;

    pd_rx #(.DUMMY_BITS(DUMMY_BITS), .SIG_W(8), .SIG(SIG)) rx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (cs_n_s),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .mosi_s    (mosi_s),
        .cmd_next  (cmd_next),
        .op_byte   (op_byte),
        .op_strobe (op_strobe),
        .cmd_q     (cmd_q),
        .op_exact  (op_exact),
        .miso      (spi_miso),
        .miso_oe   (spi_miso_oe)
    );

    pd_decode #(.OP_DPD(OP_DPD), .OP_RES(OP_RES)) dec_i (
        .op_byte (op_byte),
        .busy    (busy),
        .mode    (mode),
        .cmd     (cmd_next)
    );

    pd_mode #(.TRES(TRES)) mode_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_rise  (cs_rise),
        .cmd_q    (cmd_q),
        .op_exact (op_exact),
        .mode     (mode)
    );

    assign st_standby   = (mode == MODE_STBY);
    assign st_deep_pd   = (mode == MODE_DEEP);
    assign st_releasing = (mode == MODE_REL);

    p_busy_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_strobe && busy) |=> (cmd_q == CMD_NONE));
    p_quiet_in_rel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_strobe && st_releasing) |=> (cmd_q == CMD_NONE));
endmodule

// File: tb/flash_pd_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_pd_ctrl_tb_top;
    localparam int TRES_TB = 300;
    localparam int HALF    = 8;
    localparam logic [7:0] SIGV = 8'h12;
    localparam int MS = 0, MD = 1, MR = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, busy = 1'b0;
    logic miso, oe, st_deep, st_rel, st_stby;
    int   n_checks = 0;
    int   n_errors = 0;
    int   model_mode = MS;

    always #10 clk = ~clk;

    flash_pd_ctrl #(.TRES(TRES_TB)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .spi_cs_n     (cs_n),
        .spi_sck      (sck),
        .spi_mosi     (mosi),
        .busy         (busy),
        .spi_miso     (miso),
        .spi_miso_oe  (oe),
        .st_deep_pd   (st_deep),
        .st_releasing (st_rel),
        .st_standby   (st_stby)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int mode_now();
        if ({st_deep, st_rel, st_stby} == 3'b100) return MD;
        if ({st_deep, st_rel, st_stby} == 3'b010) return MR;
        if ({st_deep, st_rel, st_stby} == 3'b001) return MS;
        return 7;
    endfunction

    // Expected mode after a transaction, from the requirements.
    function automatic int next_mode(input int m, input logic [7:0] op,
                                     input int nbits, input bit bsy);
        if (bsy || m == MR || nbits < 8) return m;
        if (op == 8'hAB) return (m == MD) ? MR : m;
        if (op == 8'hB9 && nbits == 8 && m == MS) return MD;
        return m;
    endfunction

    function automatic bit sig_expected(input int m, input logic [7:0] op, input bit bsy);
        return !bsy && m != MR && op == 8'hAB;
    endfunction

    // One transaction; checks data-out bit by bit against the expectation.
    task automatic xfer(input logic [7:0] op, input int nbits, input bit bsy,
                        input bit want_sig, input string req);
        int bad = 0, oe_bad = 0;
        busy = bsy;
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 8) ? op[7 - i] : 1'($urandom_range(0, 1));
            wait_clk(HALF);
            if (oe !== 1'b1) oe_bad++;
            if (want_sig && i >= 32) begin
                if (miso !== SIGV[7 - ((i - 32) % 8)]) bad++;
            end else if (miso !== 1'b0) bad++;
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(HALF);
        busy = 1'b0;
        chk(bad == 0, req, "data-out bit mismatches", bad, 0);
        chk(oe_bad == 0 && oe === 1'b0 && miso === 1'b0, "R11",
            "enable wrong during or after transaction", oe_bad, 0);
    endtask

    task automatic chk_mode(input int exp, input string req);
        chk(mode_now() == exp, req, "mode", mode_now(), exp);
    endtask

    // Run a transaction through the model and check the resulting mode,
    // waiting out and checking any release delay.
    task automatic run(input logic [7:0] op, input int nbits, input bit bsy, input string req);
        int nm;
        nm = next_mode(model_mode, op, nbits, bsy);
        xfer(op, nbits, bsy, sig_expected(model_mode, op, bsy), req);
        chk_mode(nm, req);
        if (nm == MR) begin
            wait_clk(TRES_TB - 24);
            chk_mode(MR, "R8");
            wait_clk(40);
            chk_mode(MS, "R8");
            nm = MS;
        end
        model_mode = nm;
    endtask

    initial begin
        #(20 * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        // R1 reset state
        chk_mode(MS, "R1");
        chk(miso === 1'b0 && oe === 1'b0, "R1", "miso/oe after reset", {miso, oe}, 0);

        // R7 R4 R5: wake-up opcode in standby streams signature, stays standby
        run(8'hAB, 56, 1'b0, "R7");
        // R2: wrong bit counts do not enter deep
        run(8'hB9, 9, 1'b0, "R2");
        run(8'hB9, 7, 1'b0, "R2");
        // R6: busy blocks entry
        run(8'hB9, 8, 1'b1, "R6");
        // R2: exact entry
        run(8'hB9, 8, 1'b0, "R2");
        // R3: other opcodes ignored in deep
        run(8'h9F, 8, 1'b0, "R3");
        run(8'hB9, 8, 1'b0, "R3");
        run(8'h9F, 48, 1'b0, "R3");
        // R9: truncated wake-up
        run(8'hAB, 5, 1'b0, "R9");
        // R6: busy blocks wake-up and signature
        run(8'hAB, 48, 1'b1, "R6");
        // R5 R8: wake-up with repeated signature and timed release
        run(8'hAB, 64, 1'b0, "R5");

        // R10: opcodes during release are ignored
        run(8'hB9, 8, 1'b0, "R2");
        xfer(8'hAB, 8, 1'b0, 1'b0, "R8");
        chk_mode(MR, "R8");
        xfer(8'hB9, 8, 1'b0, 1'b0, "R10");
        chk_mode(MR, "R10");
        wait_clk(TRES_TB);
        chk_mode(MS, "R10");
        model_mode = MS;

        // Constrained random mix
        for (int t = 0; t < 40; t++) begin
            logic [7:0] op;
            int sel, nb;
            bit bsy;
            sel = $urandom_range(0, 9);
            op  = (sel < 4) ? 8'hAB : (sel < 8) ? 8'hB9 : 8'($urandom_range(0, 255));
            nb  = ($urandom_range(0, 2) == 0) ? $urandom_range(33, 50) : $urandom_range(6, 10);
            bsy = ($urandom_range(0, 4) == 0);
            run(op, nb, bsy, "R4");
        end

        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule